// File: doc/BRIEF.md
# Serial ADC control-byte sequencer

This block is the digital serial front end of a 14-bit successive-approximation converter. A host drives a chip-select, a serial clock and a data line. The block oversamples all three with the system clock. While chip-select is low, it looks for the first 1 on the data line at a serial-clock rising edge. That bit opens a frame, and the block captures the seven control bits that follow it.

The control bits choose how the sample is coded (unipolar or bipolar), which clock runs the conversion (the serial clock or an internal one), and one of four modes. The lowest bits are loaded into a small port register that drives external selection logic.

For a conversion timed by the serial clock, the block does three things:
- It pulses a strobe for one serial-clock period.
- It latches the parallel sample input.
- It shifts the 14-bit code out MSB first, one bit per falling edge.

Calibration and internal-clock conversions are modelled as a fixed busy window counted in system clocks. Raising chip-select abandons whatever is in progress and re-arms the start-bit search.

Top module: `adc_seq_top`

## Requirements
- R1: While cs_n is low, din is sampled at each rising edge of sclk. Any number of leading 0s are ignored. The first 1 starts a frame, and the next seven sampled bits become control bits 6 down to 0. Falling edges of sclk are numbered from 1, starting at the first one after the start bit.
- R2: Control bit 6 selects the coding: 1 is unipolar, 0 is bipolar. Bit 5 selects the conversion clock: 1 is internal, 0 is sclk. Bits 4:3 select the mode: 00 is a short 24-clock conversion, 01 is calibration, 10 is power-down and 11 is a long 32-clock conversion. Bits 2:0 are the port values.
- R3: In a short conversion with the sclk-timed clock, strobe is high from falling edge 7 until falling edge 8. The result MSB appears on dout at falling edge 8. The frame ends at falling edge 24, and the start-bit search then resumes without any cs_n activity.
- R4: In a long conversion with the sclk-timed clock, strobe is high from falling edge 15 until falling edge 16. The result MSB appears on dout at falling edge 16. The frame ends at falling edge 32.
- R5: After the MSB, the remaining 13 result bits appear on dout, one per falling edge, in descending order. dout is 0 after the LSB and at every time outside a conversion frame.
- R6: sample is latched at the falling edge that raises strobe. In unipolar mode it is reported unchanged. In bipolar mode its top bit is inverted, which converts offset binary to two's complement.
- R7: port_out loads all three bits at once when the last control bit (bit 0) is sampled. It holds its value at all other times, including power-down mode and cs_n activity.
- R8: When calibration mode or the internal clock is selected, busy is high for BUSY_CYCLES system clocks from the acceptance of the control byte. During that window strobe and dout stay 0 and sclk edges are ignored. The start-bit search then resumes.
- R9: Power-down mode produces no strobe and no busy, and the block returns to the start-bit search as soon as the control byte is complete.
- R10: While cs_n is high, strobe, dout and busy are 0 and sclk is ignored. After cs_n falls again, the first 1 starts a new frame, and any frame abandoned earlier is lost.
- R11: With rst high at a clock edge, dout, strobe, busy and port_out are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than sclk |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip-select from the host |
| sclk | input | 1 | Serial clock, idle low |
| din | input | 1 | Serial control data, sampled at sclk rising edges |
| sample | input | 14 | Parallel conversion code in offset binary |
| dout | output | 1 | Serial result, MSB first, changed at sclk falling edges |
| strobe | output | 1 | One-sclk-period pulse before the result MSB |
| busy | output | 1 | High during calibration or internal-clock conversion |
| port_out | output | 3 | Port register loaded from control bits 2:0 |

## Verification
The assertions assume three things about the host:
- The serial clock is slow enough that each level lasts many system clocks, so rising and falling edges never occur in the same cycle.
- chip-select changes only while the serial clock is low.
- The sample input is steady around the strobe edge.

The bench drives every serial-clock half period as six system clocks, toggles chip-select only between bits, and holds the sample constant for the whole frame. Outputs are read on the falling system-clock edge just before the next serial-clock edge, so every registered update has settled by then.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    S_HUNT  = 2'd0,
    S_FRAME = 2'd1,
    S_BUSY  = 2'd2
  } seq_state_t;

  localparam logic [1:0] MODE_SHORT = 2'b00;
  localparam logic [1:0] MODE_CAL   = 2'b01;
  localparam logic [1:0] MODE_PDOWN = 2'b10;
  localparam logic [1:0] MODE_LONG  = 2'b11;

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/adc_seq_edge.sv
module adc_seq_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic             unipolar,
  input  logic [RES_W-1:0] sample,
  output logic             msb
);

  logic [RES_W-1:0] shreg;
  logic [RES_W-1:0] coded;

  // bipolar: offset binary to two's complement by flipping the top bit
  generate
    if (RES_W > 1) begin : g_wide
      assign coded = unipolar ? sample : {~sample[RES_W-1], sample[RES_W-2:0]};
    end else begin : g_narrow
      assign coded = unipolar ? sample : ~sample;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        shreg <= '0;
    else if (load)  shreg <= coded;
    else if (shift) shreg <= shreg << 1;
  end

  assign msb = shreg[RES_W-1];

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int PORT_W      = 3,
  parameter int SHORT_CLKS  = 24,
  parameter int LONG_CLKS   = 32,
  parameter int SHORT_STB   = 7,
  parameter int LONG_STB    = 15,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [RES_W-1:0]  sample,
  output logic              dout,
  output logic              strobe,
  output logic              busy,
  output logic [PORT_W-1:0] port_out
);

  localparam int CTL_W   = 4 + PORT_W;
  localparam int BIT_UNI = CTL_W - 1;
  localparam int BIT_INT = CTL_W - 2;
  localparam int BIT_M1  = CTL_W - 3;
  localparam int CNT_W   = $clog2(LONG_CLKS + 1);
  localparam int RCNT_W  = $clog2(CTL_W + 1);
  localparam int BCNT_W  = $clog2(BUSY_CYCLES + 1);

  localparam logic [CNT_W-1:0]  SHORT_STB_C = CNT_W'(SHORT_STB);
  localparam logic [CNT_W-1:0]  LONG_STB_C  = CNT_W'(LONG_STB);
  localparam logic [CNT_W-1:0]  SHORT_END_C = CNT_W'(SHORT_CLKS);
  localparam logic [CNT_W-1:0]  LONG_END_C  = CNT_W'(LONG_CLKS);
  localparam logic [RCNT_W-1:0] LAST_BIT_C  = RCNT_W'(CTL_W - 1);
  localparam logic [RCNT_W-1:0] ALL_BITS_C  = RCNT_W'(CTL_W);
  localparam logic [BCNT_W-1:0] BUSY_LAST_C = BCNT_W'(BUSY_CYCLES - 1);

  logic cs_s, sclk_s, din_s;
  logic rise_p, fall_p;

  adc_seq_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, sclk, din}),
    .q({cs_s, sclk_s, din_s})
  );

  adc_seq_edge u_edge (
    .clk(clk), .rst(rst), .lvl(sclk_s), .rise(rise_p), .fall(fall_p)
  );

  seq_state_t        state;
  logic [CTL_W-1:0]  ctl;
  logic [RCNT_W-1:0] rcnt;
  logic [CNT_W-1:0]  fcnt;
  logic [BCNT_W-1:0] bcnt;

  logic [1:0]        mode_f;
  logic              ext_conv, is_long, active;
  logic [CNT_W-1:0]  fcnt_n, stb_pos, msb_pos, end_pos;
  logic [RCNT_W-1:0] wr_idx;
  logic              res_load, res_shift, res_msb, byte_done, go_busy;

  always_comb begin
    mode_f    = ctl[BIT_M1 -: 2];
    is_long   = (mode_f == MODE_LONG);
    ext_conv  = !ctl[BIT_INT] && (mode_f == MODE_SHORT || is_long);
    stb_pos   = is_long ? LONG_STB_C : SHORT_STB_C;
    msb_pos   = stb_pos + CNT_W'(1);
    end_pos   = is_long ? LONG_END_C : SHORT_END_C;
    fcnt_n    = fcnt + CNT_W'(1);
    wr_idx    = LAST_BIT_C - rcnt;
    active    = !cs_s && (state == S_FRAME);
    res_load  = active && fall_p && ext_conv && (fcnt_n == stb_pos);
    res_shift = active && fall_p && ext_conv && (fcnt_n >= msb_pos);
    byte_done = active && rise_p && (rcnt == LAST_BIT_C);
    go_busy   = ctl[BIT_INT] || (mode_f == MODE_CAL);
  end

  adc_seq_result #(.RES_W(RES_W)) u_result (
    .clk(clk), .rst(rst),
    .load(res_load), .shift(res_shift),
    .unipolar(ctl[BIT_UNI]), .sample(sample),
    .msb(res_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_HUNT;
      ctl      <= '0;
      rcnt     <= '0;
      fcnt     <= '0;
      bcnt     <= '0;
      port_out <= '0;
      strobe   <= 1'b0;
      dout     <= 1'b0;
      busy     <= 1'b0;
    end else if (cs_s) begin
      state  <= S_HUNT;
      strobe <= 1'b0;
      dout   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      case (state)
        S_HUNT: begin
          if (rise_p && din_s) begin
            state <= S_FRAME;
            ctl   <= '0;
            rcnt  <= '0;
            fcnt  <= '0;
          end
        end
        S_FRAME: begin
          if (rise_p && rcnt != ALL_BITS_C) begin
            ctl[wr_idx] <= din_s;
            rcnt        <= rcnt + RCNT_W'(1);
          end
          if (byte_done) begin
            port_out <= {ctl[PORT_W-1:1], din_s};
            if (go_busy) begin
              state <= S_BUSY;
              busy  <= 1'b1;
              bcnt  <= '0;
            end else if (mode_f == MODE_PDOWN) begin
              state <= S_HUNT;
            end
          end
          if (fall_p) begin
            fcnt   <= fcnt_n;
            strobe <= res_load;
            dout   <= res_shift ? res_msb : 1'b0;
            if (fcnt_n == end_pos) begin
              state <= S_HUNT;
              dout  <= 1'b0;
            end
          end
        end
        S_BUSY: begin
          bcnt <= bcnt + BCNT_W'(1);
          if (bcnt == BUSY_LAST_C) begin
            state <= S_HUNT;
            busy  <= 1'b0;
          end
        end
        default: state <= S_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int PORT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_s,
  input logic              fall_p,
  input logic              byte_done,
  input seq_state_t        state,
  input logic              strobe,
  input logic              dout,
  input logic              busy,
  input logic [PORT_W-1:0] port_out
);

  // R3 / R4: strobe only moves at a serial falling edge or on deselect
  p_strobe_at_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (!fall_p && !cs_s) |=> $stable(strobe));

  // R5: dout is only ever high inside a frame
  p_dout_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    dout |-> (state == S_FRAME));

  // R7: the port register changes only when a control byte completes
  p_port_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !byte_done |=> $stable(port_out));

  // R8: no serial output activity while busy
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!strobe && !dout));

  // R10: deselect silences every output
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (!busy && !strobe && !dout));

endmodule

bind adc_seq_top adc_seq_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .fall_p(fall_p),
  .byte_done(byte_done), .state(state), .strobe(strobe),
  .dout(dout), .busy(busy), .port_out(port_out)
);

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;

  localparam int H = 6;
  localparam int BUSY_CYC = 64;

  logic        clk = 1'b0;
  logic        rst, cs_n, sclk, din;
  logic [13:0] sample;
  logic        dout, strobe, busy;
  logic [2:0]  port_out;

  int   total = 0;
  int   bad = 0;
  bit   finished = 0;
  logic st_a [0:40];
  logic do_a [0:40];
  int   fi;

  always #5 clk = ~clk;

  adc_seq_top u_adc_seq_top (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sample(sample), .dout(dout), .strobe(strobe), .busy(busy),
    .port_out(port_out)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_tx(input logic b);
    din  = b;
    sclk = 1'b1;
    wait_clk(H);
    sclk = 1'b0;
    wait_clk(H);
  endtask

  task automatic record();
    st_a[fi] = strobe;
    do_a[fi] = dout;
  endtask

  // leading zeros, start bit, seven control bits, then zeros up to nfalls
  task automatic frame(input int lead0, input logic [6:0] c, input int nfalls);
    for (int i = 0; i < lead0; i++) bit_tx(1'b0);
    bit_tx(1'b1);
    fi = 1;
    record();
    for (int k = 6; k >= 0; k--) begin
      bit_tx(c[k]);
      fi++;
      record();
    end
    while (fi < nfalls) begin
      bit_tx(1'b0);
      fi++;
      record();
    end
  endtask

  task automatic check_conv(input bit lng, input bit uni, input logic [13:0] smp, input int nfalls);
    int stb, msb;
    logic [13:0] code;
    stb  = lng ? 15 : 7;
    msb  = stb + 1;
    code = uni ? smp : (smp ^ 14'h2000);
    for (int f = 1; f <= nfalls; f++) begin
      check(lng ? "R4 strobe position" : "R3 strobe position", 32'(st_a[f]), 32'(f == stb));
      if (f >= msb && f < msb + 14)
        check("R5 R6 result bit", 32'(do_a[f]), 32'(code[13-(f-msb)]));
      else
        check("R5 dout zero outside data", 32'(do_a[f]), 32'h0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; sample = '0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    check("R11 dout after reset", 32'(dout), 0);
    check("R11 strobe after reset", 32'(strobe), 0);
    check("R11 busy after reset", 32'(busy), 0);
    check("R11 port after reset", 32'(port_out), 0);
  endtask

  task automatic t_short_uni();
    sample = 14'h2A5C;
    cs_n = 1'b0; wait_clk(2*H);
    frame(3, 7'b1_0_00_101, 24);   // R1 leading zeros ignored
    check_conv(1'b0, 1'b1, 14'h2A5C, 24);
    check("R7 R2 port load short", 32'(port_out), 32'h5);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic t_long_bip();
    sample = 14'h1F37;
    cs_n = 1'b0; wait_clk(2*H);
    frame(0, 7'b0_0_11_010, 32);
    check_conv(1'b1, 1'b0, 14'h1F37, 32);
    check("R7 R2 port load long", 32'(port_out), 32'h2);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic t_back_to_back();
    cs_n = 1'b0; wait_clk(2*H);
    sample = 14'h0F0F;
    frame(1, 7'b1_0_00_011, 24);
    check_conv(1'b0, 1'b1, 14'h0F0F, 24);
    sample = 14'h3333;
    frame(2, 7'b0_0_11_110, 32);   // R1 R3 search resumes without cs_n activity
    check_conv(1'b1, 1'b0, 14'h3333, 32);
    check("R7 port after second frame", 32'(port_out), 32'h6);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic t_abort();
    sample = 14'h3C01;
    cs_n = 1'b0; wait_clk(2*H);
    frame(0, 7'b1_0_11_001, 16);
    check("R4 MSB before abort", 32'(do_a[16]), 32'h1);
    cs_n = 1'b1;
    wait_clk(4*H);
    check("R10 dout low on deselect", 32'(dout), 0);
    check("R10 strobe low on deselect", 32'(strobe), 0);
    bit_tx(1'b1);                   // ignored while deselected
    check("R10 sclk ignored when deselected", 32'(dout), 0);
    cs_n = 1'b0; wait_clk(2*H);
    sample = 14'h0155;
    frame(1, 7'b1_0_00_100, 24);
    check_conv(1'b0, 1'b1, 14'h0155, 24);
    check("R10 port after re-arm", 32'(port_out), 32'h4);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic t_cal();
    cs_n = 1'b0; wait_clk(2*H);
    frame(0, 7'b0_0_01_111, 8);
    check("R8 busy during calibration", 32'(busy), 1);
    check("R7 port load calibration", 32'(port_out), 32'h7);
    for (int f = 1; f <= 8; f++) check("R8 no strobe in calibration", 32'(st_a[f]), 0);
    for (int i = 0; i < 3; i++) bit_tx(1'b1);   // ignored while busy
    check("R8 busy still high", 32'(busy), 1);
    check("R8 dout quiet while busy", 32'(dout), 0);
    wait_clk(BUSY_CYC);
    check("R8 busy ends", 32'(busy), 0);
    sample = 14'h2001;
    frame(0, 7'b1_0_00_111, 24);
    check_conv(1'b0, 1'b1, 14'h2001, 24);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic t_internal();
    cs_n = 1'b0; wait_clk(2*H);
    frame(0, 7'b1_1_00_011, 8);
    check("R8 R2 busy with internal clock", 32'(busy), 1);
    wait_clk(BUSY_CYC + 10);
    check("R8 internal busy ends", 32'(busy), 0);
    check("R8 dout after internal", 32'(dout), 0);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic t_pdown();
    cs_n = 1'b0; wait_clk(2*H);
    frame(0, 7'b1_0_10_110, 8);
    check("R9 no busy in power-down", 32'(busy), 0);
    check("R7 port load power-down", 32'(port_out), 32'h6);
    for (int f = 1; f <= 8; f++) check("R9 no strobe in power-down", 32'(st_a[f]), 0);
    sample = 14'h1234;
    frame(0, 7'b0_0_00_001, 24);   // R9 back to the search at once
    check_conv(1'b0, 1'b0, 14'h1234, 24);
    cs_n = 1'b1; wait_clk(2*H);
    cs_n = 1'b0; wait_clk(2*H);
    check("R7 port holds across cs_n", 32'(port_out), 32'h1);
    cs_n = 1'b1; wait_clk(2*H);
  endtask

  task automatic t_reset_ports();
    rst = 1'b1; wait_clk(2);
    rst = 1'b0; wait_clk(2);
    check("R11 port cleared by reset", 32'(port_out), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_short_uni();
    t_long_bip();
    t_back_to_back();
    t_abort();
    t_cal();
    t_internal();
    t_pdown();
    t_reset_ports();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule